// File: doc/BRIEF.md
# GPIO Bank Register File with Masked Writes

This block holds the control state for one bank of general-purpose pins, split into ports of eight pins each. Every port has three writable control registers and one read-only input register. The control registers are a pin enable, which hands the pin to this block, a drive enable and an output level. The input register shows the pad level after a two-stage synchronizer. The pad output enable is raised only for pins that have both the pin enable and the drive enable set.

Each control register can also be reached through a second address window. A write there carries a per-pin select mask in bits [15:8] and the new levels in bits [7:0]. Software can therefore flip one pin without reading the register first, and two agents that own different pins of the same port cannot overwrite each other's pins. A plain write replaces all eight bits in one access, which suits restoring a whole port at once.

The address of a register is made up of three fields. Bits [3:2] select the port. Bits [5:4] select the group: 0 is the pin enable, 1 the drive enable, 2 the output level and 3 the input. Bit 7 selects the masked window. Bits [1:0] and bit 6 are ignored.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, every pin enable, drive enable and output level bit is 0, so gpio_oe_o and gpio_out_o are all 0 and every control register reads 0.
- R2: A plain write (addr bit 7 = 0) to group 0, 1 or 2 of port p replaces all eight bits of that register with wdata_i[7:0]. No other register changes.
- R3: A write in the masked window (addr bit 7 = 1) to group 0, 1 or 2 loads wdata_i[k] into bit k only where wdata_i[8+k] is 1. All other bits keep their value, and a select of all zeros changes nothing.
- R4: gpio_oe_o[8p+k] is 1 exactly when both pin enable bit k and drive enable bit k of port p are 1.
- R5: gpio_out_o[8p+k] equals output level bit k of port p.
- R6: The input register of port p (group 3) shows gpio_in_i[8p+7:8p] through two flops. A read issued on the edge after the input changes, or on the edge after that, still returns the old level. A read issued on the third edge returns the new level.
- R7: Writes to group 3, in either window, change no register and no pad output.
- R8: A read (req_i=1, we_i=0) returns its data on rdata_o after the clock edge that samples the request, with bits [31:8] zero. A read in the masked window returns the same register as the plain address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data (masked window: [15:8] select, [7:0] value) |
| rdata_o | output | 32 | Read data, registered |
| gpio_in_i | input | 32 | Pad input levels |
| gpio_out_o | output | 32 | Pad output levels |
| gpio_oe_o | output | 32 | Pad output enables |

## Verification
Several properties are checked on every cycle. Unselected bits must survive a masked write, and a plain write must load its full byte. A pad must never be driven while its pin enable is clear. Writes to the input group must leave all state untouched. The synchronizer must show the pad level from exactly two cycles earlier, and the upper read bits must stay zero. Other behaviour can only be shown by the bench's scenarios: read-back through both windows, the reset values seen through reads, that ports are independent, and the exact read latency for a changing input.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    GRP_EN  = 2'd0,
    GRP_OE  = 2'd1,
    GRP_OUT = 2'd2,
    GRP_IN  = 2'd3
  } grp_e;

  localparam int unsigned GRP_LSB  = 4;
  localparam int unsigned PORT_LSB = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

  // checker-only warm-up count so $past(,2) stays inside the post-reset window
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R6
  sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         masked_i,
  input  grp_e         grp_i,
  input  logic [W-1:0] sel_i,
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] in_o,
  output logic [W-1:0] pad_oe_o
);
  logic [W-1:0] en_q, oe_q, out_q;
  logic [W-1:0] eff_sel;

  // plain writes select every bit
  assign eff_sel = masked_i ? sel_i : '1;

  function automatic logic [W-1:0] merge(input logic [W-1:0] old_v,
                                         input logic [W-1:0] sel,
                                         input logic [W-1:0] val);
    return (old_v & ~sel) | (val & sel);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      oe_q  <= '0;
      out_q <= '0;
    end else if (wr_i) begin
      unique case (grp_i)
        GRP_EN:  en_q  <= merge(en_q, eff_sel, val_i);
        GRP_OE:  oe_q  <= merge(oe_q, eff_sel, val_i);
        GRP_OUT: out_q <= merge(out_q, eff_sel, val_i);
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (in_o)
  );

  assign en_o     = en_q;
  assign oe_o     = oe_q;
  assign out_o    = out_q;
  assign pad_oe_o = en_q & oe_q;

  // R3
  mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && masked_i && grp_i == GRP_OUT) |=>
      ((out_q & ~$past(sel_i)) == ($past(out_q) & ~$past(sel_i))));

  // R2
  plain_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !masked_i && grp_i == GRP_EN) |=> (en_q == $past(val_i)));

  // R4
  pad_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o & ~en_q) == '0));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned MASK_BIT  = 7
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_i,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rdata_o,
  input  logic [NUM_PORTS*PORT_W-1:0]     gpio_in_i,
  output logic [NUM_PORTS*PORT_W-1:0]     gpio_out_o,
  output logic [NUM_PORTS*PORT_W-1:0]     gpio_oe_o
);
  localparam int unsigned NUM_PINS = NUM_PORTS * PORT_W;
  localparam int unsigned PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  grp_e              grp;
  logic [PIDX_W-1:0] port_idx;
  logic              masked;
  logic              wr;

  assign grp      = grp_e'(addr_i[GRP_LSB +: 2]);
  assign port_idx = addr_i[PORT_LSB +: PIDX_W];
  assign masked   = addr_i[MASK_BIT];
  assign wr       = req_i && we_i;

  logic [PORT_W-1:0] en_arr  [NUM_PORTS];
  logic [PORT_W-1:0] oe_arr  [NUM_PORTS];
  logic [PORT_W-1:0] out_arr [NUM_PORTS];
  logic [PORT_W-1:0] in_arr  [NUM_PORTS];
  logic [NUM_PINS-1:0] en_all, oe_all;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic wr_p;
    assign wr_p = wr && (port_idx == PIDX_W'(p));

    gpio_port_regs #(.W(PORT_W)) u_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_p),
      .masked_i(masked),
      .grp_i   (grp),
      .sel_i   (wdata_i[PORT_W +: PORT_W]),
      .val_i   (wdata_i[0 +: PORT_W]),
      .pin_i   (gpio_in_i[p*PORT_W +: PORT_W]),
      .en_o    (en_arr[p]),
      .oe_o    (oe_arr[p]),
      .out_o   (out_arr[p]),
      .in_o    (in_arr[p]),
      .pad_oe_o(gpio_oe_o[p*PORT_W +: PORT_W])
    );

    assign gpio_out_o[p*PORT_W +: PORT_W] = out_arr[p];
    assign en_all[p*PORT_W +: PORT_W]     = en_arr[p];
    assign oe_all[p*PORT_W +: PORT_W]     = oe_arr[p];
  end

  logic [PORT_W-1:0] rd_sel;
  always_comb begin
    unique case (grp)
      GRP_EN:  rd_sel = en_arr[port_idx];
      GRP_OE:  rd_sel = oe_arr[port_idx];
      GRP_OUT: rd_sel = out_arr[port_idx];
      default: rd_sel = in_arr[port_idx];
    endcase
  end

  logic [PORT_W-1:0] rdata_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (req_i && !we_i) rdata_q <= rd_sel;
  end

  assign rdata_o = {{(DATA_W-PORT_W){1'b0}}, rdata_q};

  logic unused_bits;
  assign unused_bits = ^{addr_i, wdata_i};

  // R7
  in_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && grp == GRP_IN) |=>
      ($stable(en_all) && $stable(oe_all) && $stable(gpio_out_o) && $stable(gpio_oe_o)));

  // R8
  rdata_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[DATA_W-1:PORT_W] == '0));

  // R4
  pad_oe_needs_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gpio_oe_o & ~(en_all & oe_all)) == '0));
endmodule

// File: tb/gpio_bank_regs_test.sv
module gpio_bank_regs_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] gin = 32'h3C5A_0F81;
  logic [31:0] gout, goe;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  gpio_bank_regs uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .gpio_in_i(gin), .gpio_out_o(gout),
    .gpio_oe_o(goe)
  );

  // {we, addr, wdata[15:0], expected read byte}
  localparam int NV = 18;
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 8'h00, 16'h00FF, 8'h00},  // R2 en p0 <= FF
    {1'b0, 8'h00, 16'h0000, 8'hFF},  // R2
    {1'b1, 8'h24, 16'h00A5, 8'h00},  // R2 out p1 <= A5
    {1'b0, 8'h24, 16'h0000, 8'hA5},  // R2
    {1'b0, 8'h20, 16'h0000, 8'h00},  // R2 p0 out untouched
    {1'b1, 8'h80, 16'h0F00, 8'h00},  // R3 clear low nibble of en p0
    {1'b0, 8'h00, 16'h0000, 8'hF0},  // R3
    {1'b1, 8'hA4, 16'hC342, 8'h00},  // R3 sel C3 val 42
    {1'b0, 8'h24, 16'h0000, 8'h66},  // R3
    {1'b0, 8'hA4, 16'h0000, 8'h66},  // R8 alias read
    {1'b0, 8'h30, 16'h0000, 8'h81},  // R6 input p0
    {1'b0, 8'h3C, 16'h0000, 8'h3C},  // R6 input p3
    {1'b1, 8'h10, 16'h000F, 8'h00},  // R2 oe p0 <= 0F
    {1'b1, 8'h90, 16'h00FF, 8'h00},  // R3 zero select
    {1'b0, 8'h10, 16'h0000, 8'h0F},  // R3
    {1'b1, 8'h30, 16'hFFFF, 8'h00},  // R7 plain input write
    {1'b1, 8'hB0, 16'hFFFF, 8'h00},  // R7 masked input write
    {1'b0, 8'h00, 16'h0000, 8'hF0}   // R7 en p0 kept
  };

  task automatic check(input string req_s, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req_s, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] r);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    r = rdata;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 out", gout, 32'h0);
    check("R1 oe", goe, 32'h0);
    for (int g = 0; g < 3; g++) begin
      for (int p = 0; p < 4; p++) begin
        access(1'b0, 8'((g << 4) | (p << 2)), 32'h0, r);
        check("R1 reg", r, 32'h0);
      end
    end

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][32], VEC[i][31:24], {16'h0, VEC[i][23:8]}, r);
      if (!VEC[i][32]) check("R2/R3/R6/R7/R8 table", r, {24'h0, VEC[i][7:0]});
    end

    // R5 pads follow output levels
    check("R5 out p1", {24'h0, gout[15:8]}, 32'h66);
    // R4 en F0 & oe 0F
    check("R4 oe p0", {24'h0, goe[7:0]}, 32'h00);
    access(1'b1, 8'h10, 32'h0000_00FF, r);
    check("R4 oe p0 both", {24'h0, goe[7:0]}, 32'hF0);
    check("R4 other ports", {8'h0, goe[31:8]}, 32'h0);
    // R7 write with full-select upper bits in input group left pads alone
    access(1'b1, 8'hB0, 32'hFFFF_FFFF, r);
    check("R7 pads", goe, 32'h0000_00F0);

    // R8 upper bits zero when wdata-like garbage in high byte
    access(1'b1, 8'h2C, 32'hDEAD_BE7E, r);
    access(1'b0, 8'h2C, 32'h0, r);
    check("R8 read", r, 32'h0000_007E);

    // R6 latency: continuous read of p0 input
    @(negedge clk);
    gin[7:0] = 8'h18;
    req = 1'b1; we = 1'b0; addr = 8'h30;
    @(negedge clk);
    check("R6 edge1 old", rdata, 32'h81);
    @(negedge clk);
    check("R6 edge2 old", rdata, 32'h81);
    @(negedge clk);
    check("R6 edge3 new", rdata, 32'h18);
    req = 1'b0;

    // R1 reset again clears state
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R1 re-reset out", gout, 32'h0);
    check("R1 re-reset oe", goe, 32'h0);
    rst_ni = 1'b1;
    access(1'b0, 8'h24, 32'h0, r);
    check("R1 re-reset reg", r, 32'h0);

    finish_run();
  end
endmodule